// File: doc/BRIEF.md
# Multi-Lane Bonding Deskew

This block lines up several receive lanes that share one clock but reach it through paths of different length. The far end puts the same bonding marker on every lane in the same symbol slot. Each lane here looks for that marker on its own. A lane that finds its marker first writes it and everything after it into its own small FIFO. It then waits. Once the slowest lane has found its marker too, every lane pops its marker in the same cycle. From then on, each output beat carries the symbols that were sent together.

While the lanes hunt for the marker, symbols that come before a lane's marker are thrown away. If the markers spread further apart than the skew budget allows, the block raises an error pulse and starts hunting again. After bonding, the block keeps checking every popped beat. A beat in which some lanes show the marker and others do not means the lanes have slipped. Bonding is then dropped and the hunt restarts.

The marker is a K-flagged symbol with value 0x7C (K28.3). Each symbol is 8 data bits plus a K flag. Lane `l` uses bits `[8l+7:8l]` of the data buses and bit `l` of the flag buses.

Top module: `deskew_bond`

## Requirements
- R1: While reset is asserted, and until the first bonding, `out_vld`, `bonded` and `skew_err` are low.
- R2: Only a symbol with its K flag set and value 0x7C counts as the marker. A data symbol of value 0x7C, or any other K symbol, does not start bonding.
- R3: During the hunt, a lane drops every symbol that comes before its marker. The first output beat after bonding carries the marker, K-flagged, on every lane.
- R4: Suppose the last lane's marker is on the inputs in cycle c, meaning it is sampled at the edge that ends cycle c. Then the aligned markers appear on the outputs in cycle c+2.
- R5: Once bonded, with every lane valid in every cycle, each output beat holds on every lane the symbols that were sent in the same slot. This holds for any lane-to-lane skew from 0 to 6 symbol times.
- R6: `bonded` rises together with the first output beat. It stays high, and `out_vld` stays high every cycle, while the markers remain aligned. `out_vld` is never high without `bonded`.
- R7: Suppose a popped beat has the marker on some lanes but not on all of them. That beat is not output, all FIFOs are flushed, `bonded` goes low in the next cycle, and the hunt restarts.
- R8: A skew of 6 cycles between the first and last marker is accepted. If the last marker has not arrived by the 6th cycle after the first, `skew_err` pulses high for one cycle, the FIFOs are flushed and the hunt restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | LANES | Per-lane symbol valid |
| in_k | input | LANES | Per-lane K flag |
| in_data | input | LANES*8 | Per-lane symbol |
| out_vld | output | 1 | Aligned beat valid |
| out_k | output | LANES | Aligned K flags |
| out_data | output | LANES*8 | Aligned symbols |
| bonded | output | 1 | Lanes are aligned |
| skew_err | output | 1 | One-cycle pulse when the marker spread exceeds the budget |

## Verification
The bench builds the block with its defaults: 4 lanes, an 8-deep FIFO per lane and a skew budget of 6.

With these values, each lane delay the bench applies is small enough to sweep. The runs cover these cases:
- a 6-cycle spread, where the earliest lane's FIFO reaches its deepest fill;
- a 7-cycle spread, which trips the error;
- identical delays;
- random delay sets.

A slipped marker injected on one lane drives a bond loss followed by a re-bond at the next marker row. Decoy symbols (a data 0x7C and K28.5) sit in the streams to show that only the true marker acts.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int SYM_W = 8;
  localparam logic [SYM_W-1:0] BOND_MARK = 8'h7C;
  typedef enum logic {ST_HUNT, ST_LOCKED} bond_st_e;
endpackage

// File: rtl/dsk_lane_fifo.sv
module dsk_lane_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q, wp_d, rp_d;

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (flush) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (wr_en) wp_d = wp_q + (AW+1)'(1);
      if (rd_en) rp_d = rp_q + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[wp_q[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rp_q[AW-1:0]];
  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
endmodule

// File: rtl/dsk_bond_ctrl.sv
module dsk_bond_ctrl import dsk_pkg::*; #(
  parameter int LANES    = 4,
  parameter int MAX_SKEW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] mark_in,
  input  logic [LANES-1:0] nempty,
  input  logic [LANES-1:0] head_mark,
  output logic [LANES-1:0] seen,
  output logic             locked,
  output logic             pop,
  output logic             flush,
  output logic             err
);
  localparam int CW = $clog2(MAX_SKEW + 2);

  bond_st_e         st_q, st_d;
  logic [LANES-1:0] seen_q, seen_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             err_q, err_d;

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    cnt_d  = cnt_q;
    err_d  = 1'b0;
    pop    = 1'b0;
    flush  = 1'b0;
    case (st_q)
      ST_HUNT: begin
        if (&seen_q) begin
          pop    = 1'b1;
          st_d   = ST_LOCKED;
          seen_d = '0;
          cnt_d  = '0;
        end else begin
          seen_d = seen_q | mark_in;
          if (|seen_q) begin
            if (!(&seen_d) && (cnt_q == CW'(MAX_SKEW))) begin
              flush  = 1'b1;
              seen_d = '0;
              cnt_d  = '0;
              err_d  = 1'b1;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end else if (|mark_in) begin
            cnt_d = CW'(1);
          end
        end
      end
      default: begin
        if (&nempty) begin
          if ((|head_mark) && !(&head_mark)) begin
            flush = 1'b1;
            st_d  = ST_HUNT;
          end else begin
            pop = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      seen_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
      err_q  <= err_d;
    end
  end

  assign seen   = seen_q;
  assign locked = (st_q == ST_LOCKED);
  assign err    = err_q;
endmodule

// File: rtl/deskew_bond.sv
module deskew_bond import dsk_pkg::*; #(
  parameter int LANES    = 4,
  parameter int DEPTH    = 8,
  parameter int MAX_SKEW = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       in_vld,
  input  logic [LANES-1:0]       in_k,
  input  logic [LANES*SYM_W-1:0] in_data,
  output logic                   out_vld,
  output logic [LANES-1:0]       out_k,
  output logic [LANES*SYM_W-1:0] out_data,
  output logic                   bonded,
  output logic                   skew_err
);
  localparam int FW = SYM_W + 1;

  logic [LANES-1:0]         mark_in, head_mark, nempty, lane_empty, lane_full;
  logic [LANES-1:0]         want_wr, wr_en, seen;
  logic [LANES-1:0][FW-1:0] head;
  logic                     locked, pop, flush, err;
  logic                     vld_q;
  logic [LANES-1:0]         k_q;
  logic [LANES*SYM_W-1:0]   data_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SYM_W-1:0] sym;
    assign sym          = in_data[l*SYM_W +: SYM_W];
    assign mark_in[l]   = in_vld[l] & in_k[l] & (sym == BOND_MARK);
    assign want_wr[l]   = in_vld[l] & ~flush & (locked | seen[l] | mark_in[l]);
    assign wr_en[l]     = want_wr[l] & (~lane_full[l] | pop);
    assign nempty[l]    = ~lane_empty[l];
    assign head_mark[l] = head[l][SYM_W] & (head[l][SYM_W-1:0] == BOND_MARK);

    dsk_lane_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (wr_en[l]),
      .wr_data ({in_k[l], sym}),
      .rd_en   (pop),
      .rd_data (head[l]),
      .empty   (lane_empty[l]),
      .full    (lane_full[l])
    );
  end

  dsk_bond_ctrl #(.LANES(LANES), .MAX_SKEW(MAX_SKEW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mark_in   (mark_in),
    .nempty    (nempty),
    .head_mark (head_mark),
    .seen      (seen),
    .locked    (locked),
    .pop       (pop),
    .flush     (flush),
    .err       (err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= pop;
  end

  always_ff @(posedge clk) begin
    if (pop) begin
      for (int l = 0; l < LANES; l++) begin
        k_q[l]                  <= head[l][SYM_W];
        data_q[l*SYM_W +: SYM_W] <= head[l][SYM_W-1:0];
      end
    end
  end

  assign out_vld  = vld_q;
  assign out_k    = k_q;
  assign out_data = data_q;
  assign bonded   = locked;
  assign skew_err = err;
endmodule

// File: rtl/dsk_bond_chk.sv
module dsk_bond_chk import dsk_pkg::*; #(
  parameter int LANES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   out_vld,
  input logic [LANES-1:0]       out_k,
  input logic [LANES*SYM_W-1:0] out_data,
  input logic                   bonded,
  input logic                   skew_err,
  input logic [LANES-1:0]       want_wr,
  input logic [LANES-1:0]       lane_full,
  input logic                   pop,
  input logic                   flush
);
  localparam int NW = $clog2(LANES + 1);

  logic [NW-1:0] mark_cnt;

  always_comb begin
    mark_cnt = '0;
    for (int l = 0; l < LANES; l++)
      if (out_k[l] && out_data[l*SYM_W +: SYM_W] == BOND_MARK) mark_cnt = mark_cnt + NW'(1);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pop && !flush |-> (want_wr & lane_full) == '0); // R5
  AST_VLD_NEEDS_BOND: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> bonded); // R6
  AST_FIRST_BEAT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bonded) |-> out_vld && (mark_cnt == NW'(LANES))); // R3
  AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (mark_cnt == '0) || (mark_cnt == NW'(LANES))); // R7
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    skew_err |=> !skew_err); // R8
  AST_ERR_UNBONDED: assert property (@(posedge clk) disable iff (!rst_n)
    skew_err |-> !bonded); // R8
endmodule

bind deskew_bond dsk_bond_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_vld   (out_vld),
  .out_k     (out_k),
  .out_data  (out_data),
  .bonded    (bonded),
  .skew_err  (skew_err),
  .want_wr   (want_wr),
  .lane_full (lane_full),
  .pop       (pop),
  .flush     (flush)
);

// File: tb/deskew_bond_bench.sv
module deskew_bond_bench;
  localparam int L    = 4;
  localparam int ROWS = 128;

  logic         clk;
  logic         rst_n;
  logic [L-1:0] in_vld, in_k, out_k;
  logic [L*8-1:0] in_data, out_data;
  logic         out_vld, bonded, skew_err;

  logic [7:0] txd [L][ROWS];
  logic       txk [L][ROWS];
  int         skew [L];
  int         nvec, nfail;
  bit         done;

  deskew_bond u_deskew_bond (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_k(in_k), .in_data(in_data),
    .out_vld(out_vld), .out_k(out_k), .out_data(out_data),
    .bonded(bonded), .skew_err(skew_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected row index on the outputs at step n, -1 when no beat is due.
  function automatic int exp_row(int n, int smax, int mode);
    if (mode == 2) return -1;
    if (n < 12 + smax) return -1;
    if (mode == 1 && n > 43 + smax && n < 60 + smax) return -1;
    return n - 2 - smax;
  endfunction

  function automatic bit exp_err(int n, int mode);
    return (mode == 2) && (n == 17 || n == 24);
  endfunction

  task automatic gen_rows(input int mode);
    for (int r = 0; r < ROWS; r++)
      for (int l = 0; l < L; l++) begin
        txk[l][r] = 1'b0;
        txd[l][r] = 8'($urandom_range(0, 255));
        if (($urandom_range(0, 7) == 0) && r > 10) begin
          txk[l][r] = 1'b1;
          txd[l][r] = 8'hBC;
        end
        if (r == 5) txd[l][r] = 8'h7C;          // R2 decoy: data 0x7C, not a marker
        if (r >= 10 && (r - 10) % 16 == 0) begin
          txk[l][r] = 1'b1;
          txd[l][r] = 8'h7C;
        end
      end
    if (mode == 1) begin                         // R7 slip on lane 0
      txk[0][42] = 1'b0; txd[0][42] = 8'h11;
      txk[0][43] = 1'b1; txd[0][43] = 8'h7C;
    end
  endtask

  task automatic drive(input int n);
    for (int l = 0; l < L; l++) begin
      int r;
      r = n - skew[l];
      in_vld[l] = 1'b1;
      if (r < 0) begin
        in_k[l] = 1'b0;
        in_data[l*8 +: 8] = 8'h00;
      end else begin
        in_k[l] = txk[l][r];
        in_data[l*8 +: 8] = txd[l][r];
      end
    end
  endtask

  task automatic run(input int s0, input int s1, input int s2, input int s3, input int mode);
    int smax, len;
    skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
    smax = 0;
    for (int l = 0; l < L; l++) if (skew[l] > smax) smax = skew[l];
    len = (mode == 2) ? 30 : 90;
    gen_rows(mode);
    rst_n = 1'b0; in_vld = '0; in_k = '0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(!out_vld && !bonded && !skew_err, "R1 reset", {out_vld, bonded, skew_err}, 0);
    rst_n = 1'b1;
    drive(0);
    for (int n = 1; n <= len; n++) begin
      int er;
      @(negedge clk);
      er = exp_row(n, smax, mode);
      chk(out_vld == (er >= 0), "R4/R6 out_vld", out_vld, er >= 0);
      chk(bonded == (er >= 0), "R6/R7 bonded", bonded, er >= 0);
      chk(skew_err == exp_err(n, mode), "R8 skew_err", skew_err, exp_err(n, mode));
      if (n == 12 + smax && mode != 2)
        chk(out_k == '1 && out_data == {L{8'h7C}}, "R3 first beat marker", {out_k, out_data}, {4'hF, {L{8'h7C}}});
      if (er >= 0 && out_vld)
        for (int l = 0; l < L; l++)
          chk(out_k[l] == txk[l][er] && out_data[l*8 +: 8] == txd[l][er], "R5/R2 lane data",
              {out_k[l], out_data[l*8 +: 8]}, {txk[l][er], txd[l][er]});
      drive(n);
    end
  endtask

  initial begin
    nvec = 0; nfail = 0; done = 1'b0;
    void'($urandom(32'd2718));
    run(0, 0, 0, 0, 0);
    run(0, 6, 3, 1, 0);
    run(6, 0, 6, 0, 0);
    for (int t = 0; t < 5; t++)
      run($urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6), 0);
    run(0, 2, 5, 3, 1);
    run(0, 7, 2, 1, 2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule